// File: doc/BRIEF.md
# Root Port Reset and Link-Up Sequencer

This block drives the active-low reset lines of one PCIe root port and reports whether the link is up. Software writes a control word that holds one release bit per reset line: PHY, PIPE soft reset, MAC soft reset, configuration-space reset and the endpoint PERST#. Each line is pulled low at once when its bit clears. It is let go only after two port-clock edges, so every release lines up with the clock. The link-training state machine sits outside this block and shows up only as a raw link-up level. That level is synchronised and then shown in a status word.

A three-bit enable field turns on an automatic reset for the case where a working link is lost. When every bit of the field is set and the synchronised link-up level falls, the block does two things. It holds the MAC and configuration resets low for a parameterised number of cycles. It also clears their release bits in the control word, so software must release them again.

The usual sequence is this: write zero, then write the release bits, then poll the status bit until the link comes up.

Top module: `port_rst_seq`

## Requirements
- R1: After reset the control word reads 0 and all five reset outputs are low.
- R2: The control word at byte offset 0x510 keeps only these fields: bit 0 PHY release, bit 1 PIPE release, bit 2 MAC release, bit 3 configuration release, bit 8 PERST# release, and bits 15:13 auto-reset enable. It reads back the last value written, ANDed with mask 0x0000E10F.
- R3: A cleared release bit drives its output low in the same cycle the control word changes. A set release bit drives its output high on the second clock edge after the write edge.
- R4: Writing 0 to the control word asserts all five resets together.
- R5: Bit 10 of the status word at byte offset 0x804 follows the link-up input two clock edges later. All other status bits read 0. Writes to the status word have no effect.
- R6: When the enable field reads 3'b111 and the synchronised link-up level falls, the MAC and configuration outputs go low and control bits 2 and 3 clear. The PHY, PIPE and PERST# bits and outputs keep their values.
- R7: When the enable field is not 3'b111, a falling link-up level changes neither the outputs nor the control word.
- R8: A rising link-up level never starts an automatic reset.
- R9: For PULSE_LEN cycles after an automatic reset starts, the MAC and configuration outputs stay low even if software sets their release bits. Once the pulse ends, those set bits release the outputs.
- R10: Any other byte offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte offset of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| linkUpRaw | input | 1 | Link-up level from the training logic, asynchronous |
| phyRstN | output | 1 | PHY reset, active low |
| pipeRstN | output | 1 | PIPE soft reset, active low |
| macRstN | output | 1 | MAC soft reset, active low |
| cfgRstN | output | 1 | Configuration-space reset, active low |
| perstN | output | 1 | Endpoint PERST#, active low |

## Verification
Random control words, with the link held steady, test that the mask and field positions are correct. They also show that each output tracks only its own bit. Directed link drops are run with the enable field complete, and again with one enable bit missing. These separate a correct falling-edge trigger from one that ignores the enable field or fires on a rising edge. Software writes made in the middle of an automatic pulse show whether the hold window is enforced and whether the cleared bits persist after the pulse.

// File: rtl/port_rst_seq_pkg.sv
package port_rst_seq_pkg;
  localparam int unsigned BIT_PHY  = 0;
  localparam int unsigned BIT_PIPE = 1;
  localparam int unsigned BIT_MAC  = 2;
  localparam int unsigned BIT_CFG  = 3;
  localparam int unsigned BIT_PERST = 8;
  localparam int unsigned BIT_LINK = 10;
  localparam int unsigned EN_LO    = 13;
  localparam int unsigned EN_W     = 3;
  localparam int unsigned NUM_LINES = 5;
  localparam logic [31:0] CTRL_MASK = 32'h0000_E10F;

  typedef struct packed {
    logic autoFire;
    logic autoHold;
  } seqStrobe_t;
endpackage

// File: rtl/rst_line_sync.sv
module rst_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic relReq,
  output logic lineRstN
);
  logic gateN;
  logic [STAGES-1:0] stage;

  assign gateN = rst_n & relReq;

  always_ff @(posedge clk or negedge gateN) begin
    if (!gateN) stage <= '0;
    else        stage <= {stage[STAGES-2:0], 1'b1};
  end

  assign lineRstN = stage[STAGES-1];
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import port_rst_seq_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            linkUpRaw,
  input  logic [EN_W-1:0] autoEn,
  output logic            linkSync,
  output seqStrobe_t      strb
);
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic [SYNC_STAGES-1:0] linkPipe;
  logic linkPrev;
  logic [CNT_W-1:0] holdCnt;
  logic fallSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      linkPipe <= '0;
      linkPrev <= 1'b0;
    end else begin
      linkPipe <= {linkPipe[SYNC_STAGES-2:0], linkUpRaw};
      linkPrev <= linkPipe[SYNC_STAGES-1];
    end
  end

  assign linkSync = linkPipe[SYNC_STAGES-1];
  assign fallSeen = linkPrev & ~linkSync;

  always_comb begin
    strb.autoFire = fallSeen && (autoEn == {EN_W{1'b1}});
    strb.autoHold = (holdCnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             holdCnt <= '0;
    else if (strb.autoFire) holdCnt <= CNT_LOAD;
    else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  p_fire_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.autoFire |-> (autoEn == {EN_W{1'b1}}));
  p_fire_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.autoFire |-> $past(linkSync) && !linkSync);
  p_fire_starts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.autoFire |=> strb.autoHold);
endmodule

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import port_rst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h510,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h804,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              linkSync,
  input  seqStrobe_t        strb,
  output logic [EN_W-1:0]   autoEn,
  output logic [NUM_LINES-1:0] lineRstN
);
  logic [31:0] ctrlReg;
  logic [NUM_LINES-1:0] relReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0;
    end else begin
      if (regWe && regAddr == CTRL_OFS) ctrlReg <= regWdata & CTRL_MASK;
      if (strb.autoFire) begin
        ctrlReg[BIT_MAC] <= 1'b0;
        ctrlReg[BIT_CFG] <= 1'b0;
      end
    end
  end

  assign autoEn = ctrlReg[EN_LO +: EN_W];

  always_comb begin
    relReq[0] = ctrlReg[BIT_PHY];
    relReq[1] = ctrlReg[BIT_PIPE];
    relReq[2] = ctrlReg[BIT_MAC] & ~strb.autoHold;
    relReq[3] = ctrlReg[BIT_CFG] & ~strb.autoHold;
    relReq[4] = ctrlReg[BIT_PERST];
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_OFS)      regRdata = ctrlReg;
    else if (regAddr == STAT_OFS) regRdata[BIT_LINK] = linkSync;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    rst_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .relReq(relReq[i]), .lineRstN(lineRstN[i]));

    p_async_assert_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !relReq[i] |-> !lineRstN[i]);
    p_release_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lineRstN[i]) |-> $past(relReq[i]));
  end

  p_fire_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.autoFire |=> !ctrlReg[BIT_MAC] && !ctrlReg[BIT_CFG]);
  p_hold_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.autoHold |-> !relReq[2] && !relReq[3]);
endmodule

// File: rtl/port_rst_seq.sv
module port_rst_seq
  import port_rst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h510,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h804,
  parameter int unsigned PULSE_LEN = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              linkUpRaw,
  output logic              phyRstN,
  output logic              pipeRstN,
  output logic              macRstN,
  output logic              cfgRstN,
  output logic              perstN
);
  logic linkSync;
  logic [EN_W-1:0] autoEn;
  seqStrobe_t strb;
  logic [NUM_LINES-1:0] lineRstN;

  rst_seq_ctrl #(.PULSE_LEN(PULSE_LEN), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .linkUpRaw(linkUpRaw), .autoEn(autoEn),
    .linkSync(linkSync), .strb(strb));

  rst_seq_dp #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS),
               .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .linkSync(linkSync),
    .strb(strb), .autoEn(autoEn), .lineRstN(lineRstN));

  assign phyRstN  = lineRstN[0];
  assign pipeRstN = lineRstN[1];
  assign macRstN  = lineRstN[2];
  assign cfgRstN  = lineRstN[3];
  assign perstN   = lineRstN[4];
endmodule

// File: tb/port_rst_seq_tb.sv
module port_rst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 16;
  localparam logic [11:0] A_CTRL = 12'h510;
  localparam logic [11:0] A_STAT = 12'h804;
  localparam logic [31:0] MASK = 32'h0000_E10F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic linkUpRaw = 1'b0;
  logic phyRstN, pipeRstN, macRstN, cfgRstN, perstN;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_rst_seq #(.PULSE_LEN(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .linkUpRaw(linkUpRaw),
    .phyRstN(phyRstN), .pipeRstN(pipeRstN), .macRstN(macRstN),
    .cfgRstN(cfgRstN), .perstN(perstN));

  function automatic logic [4:0] expLines(input logic [31:0] w);
    return {w[8], w[3], w[2], w[1], w[0]};
  endfunction

  function automatic logic [4:0] outs();
    return {perstN, cfgRstN, macRstN, pipeRstN, phyRstN};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] w;
    void'($urandom(32'd2024));
    waitCyc(3);
    rd(A_CTRL, d);
    chk("R1 ctrl", d, 32'h0);
    chk("R1 outs", 32'(outs()), 32'h0);
    rst_n = 1'b1;
    waitCyc(2);

    // R3 release timing on PHY
    wr(A_CTRL, 32'h1);
    chk("R3 phy k", 32'(phyRstN), 0);
    @(negedge clk); chk("R3 phy k+1", 32'(phyRstN), 0);
    @(negedge clk); chk("R3 phy k+2", 32'(phyRstN), 1);
    // R4 write zero asserts immediately
    wr(A_CTRL, 32'hFFFF_FFFF);
    waitCyc(3);
    chk("R2 all released", 32'(outs()), 32'h1F);
    wr(A_CTRL, 32'h0);
    chk("R4 all asserted", 32'(outs()), 32'h0);

    // R5 status follows link
    @(negedge clk); linkUpRaw = 1'b1;
    @(negedge clk); rd(A_STAT, d); chk("R5 link 1 edge", d, 32'h0);
    @(negedge clk); rd(A_STAT, d); chk("R5 link 2 edges", d, 32'h400);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R5 status write ignored", d, 32'h400);
    rd(A_CTRL, d); chk("R5 ctrl untouched", d, 32'h0);
    rd(12'h123, d); chk("R10 other addr", d, 32'h0);
    rd(12'h514, d); chk("R10 near addr", d, 32'h0);

    // random control words, link steady, enable never complete
    for (int i = 0; i < 40; i++) begin
      w = $urandom();
      w[15] = 1'b0;
      wr(A_CTRL, w);
      waitCyc(2);
      rd(A_CTRL, d); chk("R2 readback", d, w & MASK);
      chk("R2 lines", 32'(outs()), 32'(expLines(w)));
    end

    // R7 incomplete enable: drop does nothing
    wr(A_CTRL, 32'h0000_C10F);
    waitCyc(3);
    @(negedge clk); linkUpRaw = 1'b0;
    waitCyc(PULSE + 6);
    chk("R7 outs", 32'(outs()), 32'h1F);
    rd(A_CTRL, d); chk("R7 ctrl", d, 32'h0000_C10F);

    // R8 rising edge with full enable does nothing
    wr(A_CTRL, 32'h0000_E10F);
    waitCyc(3);
    @(negedge clk); linkUpRaw = 1'b1;
    waitCyc(8);
    chk("R8 outs", 32'(outs()), 32'h1F);
    rd(A_CTRL, d); chk("R8 ctrl", d, 32'h0000_E10F);

    // R6 falling edge with full enable
    @(negedge clk); linkUpRaw = 1'b0;
    waitCyc(6);
    chk("R6 outs", 32'(outs()), 32'h13);
    rd(A_CTRL, d); chk("R6 ctrl", d, 32'h0000_E103);

    // R9 rewrite during pulse is held off
    wr(A_CTRL, 32'h0000_E10F);
    waitCyc(3);
    chk("R9 held mac", 32'(macRstN), 0);
    chk("R9 held cfg", 32'(cfgRstN), 0);
    waitCyc(PULSE + 4);
    chk("R9 after pulse", 32'(outs()), 32'h1F);
    rd(A_CTRL, d); chk("R9 ctrl kept", d, 32'h0000_E10F);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule